// File: doc/BRIEF.md
# Trap Entry Controller

This block takes a trap into a hart that has machine, supervisor and user privilege. A trap event arrives with a synchronous/asynchronous flag, a cause code, the PC of the trapping instruction and a faulting address. In the same clock edge the block does four things:

- It decides whether machine or supervisor mode handles the trap.
- It stacks that mode's interrupt-enable and previous-privilege state.
- It fills that mode's cause, exception-PC and trap-value registers.
- It switches privilege and issues a one-cycle redirect carrying the handler address.

The handler address comes from the chosen mode's vector register. The surrounding pipeline supplies the delegation masks and the two vector registers as inputs. A context-load port restores privilege and the two interrupt-enable bits; the pipeline uses it on trap return and for initial setup. The block also tracks a load reservation. A reservation request sets it, and any change of privilege drops it.

Privilege encoding everywhere: user = 0, supervisor = 1, machine = 3. Code 2 is reserved.

Top module: `trap_entry_top`

## Requirements
- R1: A trap goes to supervisor only when all three hold: the current privilege is user or supervisor, the effective cause is below XLEN, and bit `cause` of the delegation mask is set. Interrupts use `intDeleg` and exceptions use `excDeleg`. Every other trap goes to machine, including a cause at or above XLEN, whose low bits are never used to index the mask.
- R2: The target cause register holds the effective cause in its low bits, zeros above, and a 1 in bit XLEN-1 for an interrupt (0 for an exception).
- R3: The target trap-value register gets `trapAddr` only for exceptions with effective cause 0, 1, 4, 5, 6, 7, 12, 13 or 15. It is written with zero for every other trap, and always for interrupts.
- R4: An exception with cause 8 (environment call) is rewritten before delegation. It becomes 8 from user, 9 from supervisor and 11 from machine.
- R5: In the target mode only, the previous-enable bit takes the old enable bit, the previous-privilege field takes the old privilege, and the enable bit is cleared. The supervisor field is 1 bit (privilege bit 0) and the machine field is 2 bits. The other mode's fields are untouched.
- R6: The target exception-PC register captures `trapPc`.
- R7: `redirect` pulses high for exactly the cycle after a trap, and `nextPc` then equals the target vector with bits [1:0] cleared. When those vector bits equal 01 and the trap is an interrupt, 4 × cause is added to that address; any other mode value, or any exception, gets no offset.
- R8: After a trap the privilege equals the target mode (supervisor = 1, machine = 3).
- R9: `resvSet` sets `resvValid`. Any cycle that changes the privilege, by trap or by context load, clears it, and the clear takes priority over a set in that cycle.
- R10: A context load sets the privilege, `mIe` and `sIe`. A requested privilege of 2 is taken as user. A trap in the same cycle wins and the load is dropped.
- R11: After reset the privilege is machine, `redirect` and `resvValid` are low, and all status, cause, PC and trap-value registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapValid | input | 1 | Trap event this cycle |
| trapIsIntr | input | 1 | 1 = interrupt, 0 = exception |
| trapCause | input | CAUSE_W | Raw cause code |
| trapAddr | input | XLEN | Faulting address |
| trapPc | input | XLEN | PC of the trapping instruction |
| excDeleg | input | XLEN | Exception delegation mask |
| intDeleg | input | XLEN | Interrupt delegation mask |
| mVec | input | XLEN | Machine vector register (bits [1:0] = mode) |
| sVec | input | XLEN | Supervisor vector register (bits [1:0] = mode) |
| ldValid | input | 1 | Context load strobe |
| ldPriv | input | 2 | Privilege to load |
| ldMIe | input | 1 | Machine interrupt enable to load |
| ldSIe | input | 1 | Supervisor interrupt enable to load |
| resvSet | input | 1 | Set load reservation |
| curPriv | output | 2 | Current privilege |
| mIe | output | 1 | Machine interrupt enable |
| mPie | output | 1 | Machine previous enable |
| mPp | output | 2 | Machine previous privilege |
| sIe | output | 1 | Supervisor interrupt enable |
| sPie | output | 1 | Supervisor previous enable |
| sPp | output | 1 | Supervisor previous privilege |
| mCause | output | XLEN | Machine cause register |
| mEpc | output | XLEN | Machine exception PC |
| mTval | output | XLEN | Machine trap value |
| sCause | output | XLEN | Supervisor cause register |
| sEpc | output | XLEN | Supervisor exception PC |
| sTval | output | XLEN | Supervisor trap value |
| nextPc | output | XLEN | Handler address |
| redirect | output | 1 | Handler address valid |
| resvValid | output | 1 | Load reservation held |

## Verification
The properties assume the trap fields carry meaning only in cycles where `trapValid` is high. They also assume `curPriv` never holds the reserved code, because the only way to write privilege is a trap or a context load that remaps code 2. The stimulus offers at most one trap per cycle and keeps causes within CAUSE_W bits. Before each table vector it sets privilege and both enables to known values through the context-load port, so the stacked fields are predictable. The directed cases drive a trap and a load together to exercise the priority between them, and probe the reservation against privilege changes both with and without a move.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

  localparam logic [1:0] PRIV_U    = 2'b00;
  localparam logic [1:0] PRIV_S    = 2'b01;
  localparam logic [1:0] PRIV_RSVD = 2'b10;
  localparam logic [1:0] PRIV_M    = 2'b11;

  localparam int unsigned ENV_CALL_U = 8;
  localparam int unsigned ENV_CALL_S = 9;
  localparam int unsigned ENV_CALL_M = 11;

  localparam logic [1:0] VEC_MODE_SPREAD = 2'b01;

  // strobes from control to datapath
  typedef struct packed {
    logic takeM;
    logic takeS;
    logic loadCtx;
    logic keepTval;
    logic vecOffset;
  } trap_strb_t;

  // exception codes that carry a faulting address
  function automatic logic carriesAddr(input logic [31:0] code);
    case (code)
      32'd0, 32'd1, 32'd4, 32'd5, 32'd6, 32'd7,
      32'd12, 32'd13, 32'd15: carriesAddr = 1'b1;
      default:                carriesAddr = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic               trapValid,
  input  logic               trapIsIntr,
  input  logic [CAUSE_W-1:0] trapCause,
  input  logic               ldValid,
  input  logic [1:0]         curPriv,
  input  logic [XLEN-1:0]    excDeleg,
  input  logic [XLEN-1:0]    intDeleg,
  input  logic [1:0]         mVecMode,
  input  logic [1:0]         sVecMode,
  output trap_strb_t         strb,
  output logic [CAUSE_W-1:0] effCause
);

  localparam int IDX_W = $clog2(XLEN);

  logic             inRange;
  logic             lowPriv;
  logic             maskBit;
  logic             goS;
  logic [IDX_W-1:0] maskIdx;
  logic [1:0]       tgtMode;

  // environment-call rewrite by current privilege
  always_comb begin
    effCause = trapCause;
    if (!trapIsIntr && trapCause == CAUSE_W'(ENV_CALL_U)) begin
      case (curPriv)
        PRIV_M:  effCause = CAUSE_W'(ENV_CALL_M);
        PRIV_S:  effCause = CAUSE_W'(ENV_CALL_S);
        default: effCause = CAUSE_W'(ENV_CALL_U);
      endcase
    end
  end

  // delegation decision
  always_comb begin
    inRange = 32'(effCause) < 32'(XLEN);
    maskIdx = effCause[IDX_W-1:0];
    lowPriv = (curPriv == PRIV_U) || (curPriv == PRIV_S);
    maskBit = trapIsIntr ? intDeleg[maskIdx] : excDeleg[maskIdx];
    goS     = trapValid && lowPriv && inRange && maskBit;
    tgtMode = goS ? sVecMode : mVecMode;
  end

  always_comb begin
    strb.takeS     = goS;
    strb.takeM     = trapValid && !goS;
    strb.loadCtx   = ldValid && !trapValid;
    strb.keepTval  = !trapIsIntr && carriesAddr(32'(effCause));
    strb.vecOffset = trapIsIntr && (tgtMode == VEC_MODE_SPREAD);
  end

endmodule

// File: rtl/trap_entry_dp.sv
module trap_entry_dp
  import trap_entry_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              CAUSE_W  = 6,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  trap_strb_t         strb,
  input  logic [CAUSE_W-1:0] effCause,
  input  logic               trapIsIntr,
  input  logic [XLEN-1:0]    trapAddr,
  input  logic [XLEN-1:0]    trapPc,
  input  logic [XLEN-1:0]    mVec,
  input  logic [XLEN-1:0]    sVec,
  input  logic [1:0]         ldPriv,
  input  logic               ldMIe,
  input  logic               ldSIe,
  input  logic               resvSet,
  output logic [1:0]         curPriv,
  output logic               mIe,
  output logic               mPie,
  output logic [1:0]         mPp,
  output logic               sIe,
  output logic               sPie,
  output logic               sPp,
  output logic [XLEN-1:0]    mCause,
  output logic [XLEN-1:0]    mEpc,
  output logic [XLEN-1:0]    mTval,
  output logic [XLEN-1:0]    sCause,
  output logic [XLEN-1:0]    sEpc,
  output logic [XLEN-1:0]    sTval,
  output logic [XLEN-1:0]    nextPc,
  output logic               redirect,
  output logic               resvValid
);

  logic [XLEN-1:0] tgtVec;
  logic [XLEN-1:0] vecOff;
  logic [XLEN-1:0] vecPc;
  logic [XLEN-1:0] causeWord;
  logic [XLEN-1:0] tvalWord;
  logic [1:0]      ldPrivEff;
  logic [1:0]      privNext;
  logic            privMoves;
  logic            anyTrap;

  always_comb begin
    anyTrap   = strb.takeM || strb.takeS;
    tgtVec    = strb.takeS ? sVec : mVec;
    vecOff    = strb.vecOffset ? (XLEN'(effCause) << 2) : '0;
    vecPc     = {tgtVec[XLEN-1:2], 2'b00} + vecOff;
    causeWord = {trapIsIntr, (XLEN-1)'(effCause)};
    tvalWord  = strb.keepTval ? trapAddr : '0;
    ldPrivEff = (ldPriv == PRIV_RSVD) ? PRIV_U : ldPriv;
    if (strb.takeS)        privNext = PRIV_S;
    else if (strb.takeM)   privNext = PRIV_M;
    else if (strb.loadCtx) privNext = ldPrivEff;
    else                   privNext = curPriv;
    privMoves = privNext != curPriv;
  end

  // privilege, redirect and reservation
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPriv   <= PRIV_M;
      redirect  <= 1'b0;
      nextPc    <= RESET_PC;
      resvValid <= 1'b0;
    end else begin
      curPriv  <= privNext;
      redirect <= anyTrap;
      if (anyTrap) nextPc <= vecPc;
      if (privMoves)    resvValid <= 1'b0;
      else if (resvSet) resvValid <= 1'b1;
    end
  end

  // machine trap registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mIe    <= 1'b0;
      mPie   <= 1'b0;
      mPp    <= 2'b00;
      mCause <= '0;
      mEpc   <= '0;
      mTval  <= '0;
    end else if (strb.takeM) begin
      mPie   <= mIe;
      mPp    <= curPriv;
      mIe    <= 1'b0;
      mCause <= causeWord;
      mEpc   <= trapPc;
      mTval  <= tvalWord;
    end else if (strb.loadCtx) begin
      mIe    <= ldMIe;
    end
  end

  // supervisor trap registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sIe    <= 1'b0;
      sPie   <= 1'b0;
      sPp    <= 1'b0;
      sCause <= '0;
      sEpc   <= '0;
      sTval  <= '0;
    end else if (strb.takeS) begin
      sPie   <= sIe;
      sPp    <= curPriv[0];
      sIe    <= 1'b0;
      sCause <= causeWord;
      sEpc   <= trapPc;
      sTval  <= tvalWord;
    end else if (strb.loadCtx) begin
      sIe    <= ldSIe;
    end
  end

endmodule

// File: rtl/trap_entry_top.sv
module trap_entry_top
  import trap_entry_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              CAUSE_W  = 6,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trapValid,
  input  logic               trapIsIntr,
  input  logic [CAUSE_W-1:0] trapCause,
  input  logic [XLEN-1:0]    trapAddr,
  input  logic [XLEN-1:0]    trapPc,
  input  logic [XLEN-1:0]    excDeleg,
  input  logic [XLEN-1:0]    intDeleg,
  input  logic [XLEN-1:0]    mVec,
  input  logic [XLEN-1:0]    sVec,
  input  logic               ldValid,
  input  logic [1:0]         ldPriv,
  input  logic               ldMIe,
  input  logic               ldSIe,
  input  logic               resvSet,
  output logic [1:0]         curPriv,
  output logic               mIe,
  output logic               mPie,
  output logic [1:0]         mPp,
  output logic               sIe,
  output logic               sPie,
  output logic               sPp,
  output logic [XLEN-1:0]    mCause,
  output logic [XLEN-1:0]    mEpc,
  output logic [XLEN-1:0]    mTval,
  output logic [XLEN-1:0]    sCause,
  output logic [XLEN-1:0]    sEpc,
  output logic [XLEN-1:0]    sTval,
  output logic [XLEN-1:0]    nextPc,
  output logic               redirect,
  output logic               resvValid
);

  trap_strb_t         strb;
  logic [CAUSE_W-1:0] effCause;

  trap_entry_ctrl #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) ctrl (
    .trapValid (trapValid),
    .trapIsIntr(trapIsIntr),
    .trapCause (trapCause),
    .ldValid   (ldValid),
    .curPriv   (curPriv),
    .excDeleg  (excDeleg),
    .intDeleg  (intDeleg),
    .mVecMode  (mVec[1:0]),
    .sVecMode  (sVec[1:0]),
    .strb      (strb),
    .effCause  (effCause)
  );

  trap_entry_dp #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .RESET_PC(RESET_PC)) dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .effCause  (effCause),
    .trapIsIntr(trapIsIntr),
    .trapAddr  (trapAddr),
    .trapPc    (trapPc),
    .mVec      (mVec),
    .sVec      (sVec),
    .ldPriv    (ldPriv),
    .ldMIe     (ldMIe),
    .ldSIe     (ldSIe),
    .resvSet   (resvSet),
    .curPriv   (curPriv),
    .mIe       (mIe),
    .mPie      (mPie),
    .mPp       (mPp),
    .sIe       (sIe),
    .sPie      (sPie),
    .sPp       (sPp),
    .mCause    (mCause),
    .mEpc      (mEpc),
    .mTval     (mTval),
    .sCause    (sCause),
    .sEpc      (sEpc),
    .sTval     (sTval),
    .nextPc    (nextPc),
    .redirect  (redirect),
    .resvValid (resvValid)
  );

endmodule

// File: rtl/trap_entry_checker.sv
module trap_entry_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            trapValid,
  input logic            trapIsIntr,
  input logic [XLEN-1:0] trapPc,
  input logic [1:0]      curPriv,
  input logic            mIe,
  input logic [XLEN-1:0] mCause,
  input logic [XLEN-1:0] mEpc,
  input logic            redirect,
  input logic            resvValid
);

  assert_redirect_R7: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> redirect);

  assert_redirect_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    !trapValid |=> !redirect);

  assert_machine_stays_R1: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && curPriv == 2'b11) |=> curPriv == 2'b11);

  assert_target_priv_R8: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> (curPriv == 2'b11 || curPriv == 2'b01));

  assert_mie_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && curPriv == 2'b11) |=> !mIe);

  assert_intr_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && curPriv == 2'b11) |=> mCause[XLEN-1] == $past(trapIsIntr));

  assert_epc_R6: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && curPriv == 2'b11) |=> mEpc == $past(trapPc));

  assert_resv_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curPriv) |-> !resvValid);

endmodule

bind trap_entry_top trap_entry_checker #(.XLEN(XLEN)) chk (.*);

// File: tb/trap_entry_top_test.sv
`timescale 1ns/100ps
module trap_entry_top_test;

  localparam int XLEN = 32;
  localparam int CW   = 6;
  localparam logic [31:0] ADDR  = 32'hDEAD_BEEF;
  localparam logic [31:0] MVEC0 = 32'h8000_0101;
  localparam logic [31:0] SVEC0 = 32'h4000_0200;

  typedef struct packed {
    logic [1:0]  pr;
    logic        intr;
    logic [5:0]  cause;
    logic [1:0]  expPriv;
    logic [31:0] expCause;
    logic        expTv;
    logic [31:0] expPc;
  } vec_t;

  // excDeleg bits 2,8,13 ; intDeleg bits 1,5
  localparam vec_t VECS [13] = '{
    '{2'd0, 1'b0, 6'd2,  2'd1, 32'h0000_0002, 1'b0, 32'h4000_0200},
    '{2'd0, 1'b0, 6'd8,  2'd1, 32'h0000_0008, 1'b0, 32'h4000_0200},
    '{2'd1, 1'b0, 6'd8,  2'd3, 32'h0000_0009, 1'b0, 32'h8000_0100},
    '{2'd3, 1'b0, 6'd8,  2'd3, 32'h0000_000B, 1'b0, 32'h8000_0100},
    '{2'd0, 1'b0, 6'd13, 2'd1, 32'h0000_000D, 1'b1, 32'h4000_0200},
    '{2'd0, 1'b0, 6'd5,  2'd3, 32'h0000_0005, 1'b1, 32'h8000_0100},
    '{2'd3, 1'b0, 6'd13, 2'd3, 32'h0000_000D, 1'b1, 32'h8000_0100},
    '{2'd0, 1'b1, 6'd5,  2'd1, 32'h8000_0005, 1'b0, 32'h4000_0200},
    '{2'd0, 1'b1, 6'd7,  2'd3, 32'h8000_0007, 1'b0, 32'h8000_011C},
    '{2'd3, 1'b1, 6'd1,  2'd3, 32'h8000_0001, 1'b0, 32'h8000_0104},
    '{2'd0, 1'b0, 6'd34, 2'd3, 32'h0000_0022, 1'b0, 32'h8000_0100},
    '{2'd1, 1'b0, 6'd2,  2'd1, 32'h0000_0002, 1'b0, 32'h4000_0200},
    '{2'd1, 1'b0, 6'd12, 2'd3, 32'h0000_000C, 1'b1, 32'h8000_0100}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trapValid = 1'b0, trapIsIntr = 1'b0;
  logic [CW-1:0] trapCause = '0;
  logic [31:0] trapAddr = ADDR, trapPc = '0;
  logic [31:0] excDeleg = 32'h0000_2104, intDeleg = 32'h0000_0022;
  logic [31:0] mVec = MVEC0, sVec = SVEC0;
  logic ldValid = 1'b0, ldMIe = 1'b0, ldSIe = 1'b0, resvSet = 1'b0;
  logic [1:0] ldPriv = 2'd0;
  logic [1:0] curPriv, mPp;
  logic mIe, mPie, sIe, sPie, sPp, redirect, resvValid;
  logic [31:0] mCause, mEpc, mTval, sCause, sEpc, sTval, nextPc;

  int nChecks = 0;
  int nFails  = 0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  trap_entry_top #(.XLEN(XLEN), .CAUSE_W(CW)) uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doLoad(input logic [1:0] p, input logic mi, input logic si);
    @(negedge clk);
    ldValid = 1'b1; ldPriv = p; ldMIe = mi; ldSIe = si;
    @(posedge clk); #1;
    ldValid = 1'b0;
  endtask

  task automatic doTrap(input logic intr, input logic [CW-1:0] c, input logic [31:0] pc);
    @(negedge clk);
    trapValid = 1'b1; trapIsIntr = intr; trapCause = c; trapPc = pc;
    @(posedge clk); #1;
    trapValid = 1'b0;
  endtask

  task automatic pulseResv();
    @(negedge clk);
    resvSet = 1'b1;
    @(posedge clk); #1;
    resvSet = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 priv", 32'(curPriv), 32'd3);
    chk("R11 redirect", 32'(redirect), 32'd0);
    chk("R11 resv", 32'(resvValid), 32'd0);
    chk("R11 mCause", mCause, 32'd0);
    chk("R11 nextPc", nextPc, 32'd0);
    chk("R11 mIe", 32'(mIe), 32'd0);
    @(negedge clk); rstN = 1'b1;

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 13; i++) begin
      logic [31:0] pc;
      pc = 32'h1000_0000 + 32'(i) * 16;
      doLoad(VECS[i].pr, 1'b1, 1'b1);
      doTrap(VECS[i].intr, VECS[i].cause, pc);
      chk($sformatf("R1/R8 priv v%0d", i), 32'(curPriv), 32'(VECS[i].expPriv));
      chk($sformatf("R7 redirect v%0d", i), 32'(redirect), 32'd1);
      chk($sformatf("R7 nextPc v%0d", i), nextPc, VECS[i].expPc);
      if (VECS[i].expPriv == 2'd3) begin
        chk($sformatf("R2/R4 mCause v%0d", i), mCause, VECS[i].expCause);
        chk($sformatf("R6 mEpc v%0d", i), mEpc, pc);
        chk($sformatf("R3 mTval v%0d", i), mTval, VECS[i].expTv ? ADDR : 32'd0);
        chk($sformatf("R5 m stack v%0d", i), {28'd0, mIe, mPie, mPp}, {28'd0, 1'b0, 1'b1, VECS[i].pr});
        chk($sformatf("R5 sIe kept v%0d", i), 32'(sIe), 32'd1);
      end else begin
        chk($sformatf("R2/R4 sCause v%0d", i), sCause, VECS[i].expCause);
        chk($sformatf("R6 sEpc v%0d", i), sEpc, pc);
        chk($sformatf("R3 sTval v%0d", i), sTval, VECS[i].expTv ? ADDR : 32'd0);
        chk($sformatf("R5 s stack v%0d", i), {29'd0, sIe, sPie, sPp}, {29'd0, 1'b0, 1'b1, VECS[i].pr[0]});
        chk($sformatf("R5 mIe kept v%0d", i), 32'(mIe), 32'd1);
      end
    end

    // R7 redirect falls after one cycle
    @(posedge clk); #1;
    chk("R7 redirect low", 32'(redirect), 32'd0);

    // R10 reserved privilege code loads as user
    doLoad(2'd2, 1'b0, 1'b0);
    chk("R10 rsvd->U", 32'(curPriv), 32'd0);

    // R9 reservation against privilege change
    pulseResv();
    chk("R9 set", 32'(resvValid), 32'd1);
    doTrap(1'b0, 6'd2, 32'h2000_0000);
    chk("R9 clear on U->S", 32'(resvValid), 32'd0);
    doLoad(2'd3, 1'b0, 1'b0);
    pulseResv();
    doTrap(1'b0, 6'd2, 32'h2000_0004);
    chk("R9 kept on M->M", 32'(resvValid), 32'd1);
    doLoad(2'd0, 1'b0, 1'b0);
    chk("R9 clear on load", 32'(resvValid), 32'd0);

    // R7 mode 3 interrupt: no offset
    mVec = 32'h8000_0103;
    doTrap(1'b1, 6'd7, 32'h2000_0008);
    chk("R7 mode3 no offset", nextPc, 32'h8000_0100);
    mVec = MVEC0;

    // R7 supervisor spread mode
    sVec = 32'h4000_0201;
    doLoad(2'd0, 1'b0, 1'b0);
    doTrap(1'b1, 6'd5, 32'h2000_000C);
    chk("R7 s spread", nextPc, 32'h4000_0214);
    sVec = SVEC0;

    // R10 trap wins over simultaneous load
    doLoad(2'd0, 1'b1, 1'b1);
    @(negedge clk);
    trapValid = 1'b1; trapIsIntr = 1'b0; trapCause = 6'd5; trapPc = 32'h2000_0010;
    ldValid = 1'b1; ldPriv = 2'd1; ldMIe = 1'b1; ldSIe = 1'b0;
    @(posedge clk); #1;
    trapValid = 1'b0; ldValid = 1'b0;
    chk("R10 trap wins priv", 32'(curPriv), 32'd3);
    chk("R10 trap wins mIe", 32'(mIe), 32'd0);
    chk("R10 trap wins sIe", 32'(sIe), 32'd1);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule